// File: doc/BRIEF.md
# Cross-Device Periodic Trigger Synchronizer

This block sits in the sample clock domain of one of several cooperating devices. It lets all of them act on a shared trigger in the same sample clock cycle. A free-running phase counter produces a one-cycle reference tick every N sample clock cycles, where N comes from the `period_i` input. Every device must program the same N. The ticks of different devices have no phase relation after power-up. An alignment request arms the block. On the next rising edge of a shared reference clock, which is sampled straight into the sample domain, the counter restarts at phase 0. From then on the ticks of all devices fall in the same cycle.

A master drives the trigger line. The block resynchronizes that line and detects its rising edge. It does not forward the edge at once. It holds the edge as pending and releases a one-cycle synchronized trigger on the next tick. The trigger line delay from the master to the slowest device must stay below N cycles, so that every device catches the edge before the same tick. The block measures how many cycles it added between detection and release and reports that count.

There is no data stream here, so there is no valid/ready handshake. All pins are plain level or pulse control and status signals. The block applies no back-pressure and accepts none. A trigger edge that cannot be accepted is dropped, not queued.

Top module: `xdev_trig_sync`

## Requirements
- R1: During and right after reset, `aligned_o`=0, `sync_trig_o`=0 and `delay_o`=0. The phase counter sits at phase 0, so `tick_o`=1 in the first cycle after reset.
- R2: `tick_o` is high for exactly one cycle at phase 0. The phase advances by one each cycle and returns to 0 from any phase greater than or equal to `period_i`-1. With a constant `period_i` of at least 2, consecutive ticks are exactly `period_i` cycles apart.
- R3: After an alignment request, a reference edge is the first cycle, after the request cycle, in which `ref_clk_i` is 1 and was 0 in the previous cycle. At that edge the phase restarts, with one register of latency. `tick_o` and `aligned_o` both go high in the next cycle.
- R4: A cycle with `align_req_i`=1 drives `aligned_o` to 0 in the next cycle. It also discards any pending trigger. `aligned_o` stays 0 until the restart of R3.
- R5: A trigger edge detected while `aligned_o`=0 is ignored. It produces no `sync_trig_o` and leaves `delay_o` unchanged.
- R6: `trig_i` passes through two synchronizer flops. An edge whose first high sample is in cycle c is detected in cycle c+2. `sync_trig_o` then pulses for one cycle on the first tick strictly after the detection cycle, and only on a tick.
- R7: While a trigger is pending, further edges are ignored. One pending trigger yields exactly one pulse.
- R8: From the cycle after a pulse, `delay_o` equals the pulse cycle minus the detection cycle. The value lies between 1 and `period_i`, saturates at `period_i`, and holds until the next pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| period_i | input | CNT_W | Tick period N in sample cycles, at least 2 |
| align_req_i | input | 1 | One-cycle request to realign the tick phase |
| ref_clk_i | input | 1 | Shared reference clock, sampled directly |
| trig_i | input | 1 | Raw trigger line from the master device |
| tick_o | output | 1 | Periodic reference tick |
| aligned_o | output | 1 | Tick phase has been aligned since the last request |
| sync_trig_o | output | 1 | Synchronized one-cycle trigger pulse |
| delay_o | output | CNT_W | Cycles between detection and release of the last trigger |

## Verification
The bench places one trigger at every phase offset inside a period. This drives the measured delay from 1 up to exactly N. A design that counted from the raw sample instead of from detection, or that fired on the tick in the detection cycle itself, would give delays shifted by one or two cycles, or a zero delay. Further cases are a second edge inside the pending window, which a faulty design would turn into an extra pulse, and a realignment request while a trigger is pending, which a faulty design would release on the new phase. Triggers sent before alignment must leave the delay output untouched. The tests are repeated with a different period, to catch a counter that wraps at N or N+1 instead of N-1.

// File: rtl/xts_pkg.sv
package xts_pkg;
  // Alignment state of the phase counter.
  typedef enum logic [1:0] {
    ALN_FREE   = 2'd0,
    ALN_ARMED  = 2'd1,
    ALN_LOCKED = 2'd2
  } aln_state_e;
endpackage

// File: rtl/xts_align_ctl.sv
module xts_align_ctl
  import xts_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic align_req,
  input  logic ref_clk,
  output logic restart,
  output logic aligned
);
  // Single sampling register on the reference clock: fixed edge latency.
  logic       ref_q;
  logic       ref_rise;
  aln_state_e st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) ref_q <= 1'b0;
    else        ref_q <= ref_clk;
  end

  assign ref_rise = ref_clk & ~ref_q;
  assign restart  = (st_q == ALN_ARMED) & ref_rise;

  always_ff @(posedge clk) begin
    if (!rst_n)         st_q <= ALN_FREE;
    else if (align_req) st_q <= ALN_ARMED;
    else if (restart)   st_q <= ALN_LOCKED;
  end

  assign aligned = (st_q == ALN_LOCKED);
endmodule

// File: rtl/xts_phase_ctr.sv
module xts_phase_ctr #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             restart,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] last_phase;
  logic             wrap;

  assign last_phase = period - 1'b1;
  assign wrap       = (cnt_q >= last_phase);

  always_ff @(posedge clk) begin
    if (!rst_n)               cnt_q <= '0;
    else if (restart || wrap) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end

  assign tick = (cnt_q == '0);
endmodule

// File: rtl/xts_trig_capture.sv
module xts_trig_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_raw,
  input  logic accept,
  input  logic flush,
  input  logic tick,
  output logic take,
  output logic pending,
  output logic fire
);
  // Stages 0..SYNC_STAGES-1 resynchronize, the last stage holds the prior level.
  logic [SYNC_STAGES:0] sh_q;
  logic                 detect;

  for (genvar g = 0; g <= SYNC_STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q[g] <= 1'b0;
        else        sh_q[g] <= trig_raw;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (!rst_n) sh_q[g] <= 1'b0;
        else        sh_q[g] <= sh_q[g-1];
      end
    end
  end

  assign detect = sh_q[SYNC_STAGES-1] & ~sh_q[SYNC_STAGES];
  assign take   = detect & accept & ~pending & ~flush;
  assign fire   = pending & tick;

  always_ff @(posedge clk) begin
    if (!rst_n)             pending <= 1'b0;
    else if (flush || fire) pending <= 1'b0;
    else if (take)          pending <= 1'b1;
  end
endmodule

// File: rtl/xts_delay_meas.sv
module xts_delay_meas #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period,
  input  logic             start,
  input  logic             pending,
  input  logic             fire,
  output logic [CNT_W-1:0] delay
);
  logic [CNT_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_n)                                    run_q <= '0;
    else if (start)                                run_q <= {{(CNT_W-1){1'b0}}, 1'b1};
    else if (pending && !fire && (run_q < period)) run_q <= run_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    delay <= '0;
    else if (fire) delay <= run_q;
  end
endmodule

// File: rtl/xdev_trig_sync.sv
module xdev_trig_sync #(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] period_i,
  input  logic             align_req_i,
  input  logic             ref_clk_i,
  input  logic             trig_i,
  output logic             tick_o,
  output logic             aligned_o,
  output logic             sync_trig_o,
  output logic [CNT_W-1:0] delay_o
);
  logic restart;
  logic take;
  logic pending;

  xts_align_ctl u_align (
    .clk       (clk),
    .rst_n     (rst_n),
    .align_req (align_req_i),
    .ref_clk   (ref_clk_i),
    .restart   (restart),
    .aligned   (aligned_o)
  );

  xts_phase_ctr #(.CNT_W(CNT_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .period  (period_i),
    .restart (restart),
    .tick    (tick_o)
  );

  xts_trig_capture #(.SYNC_STAGES(SYNC_STAGES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_raw (trig_i),
    .accept   (aligned_o),
    .flush    (align_req_i),
    .tick     (tick_o),
    .take     (take),
    .pending  (pending),
    .fire     (sync_trig_o)
  );

  xts_delay_meas #(.CNT_W(CNT_W)) u_delay (
    .clk     (clk),
    .rst_n   (rst_n),
    .period  (period_i),
    .start   (take),
    .pending (pending),
    .fire    (sync_trig_o),
    .delay   (delay_o)
  );
endmodule

// File: rtl/xdev_trig_sync_chk.sv
module xdev_trig_sync_chk #(
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] period_i,
  input logic             align_req_i,
  input logic             tick_o,
  input logic             aligned_o,
  input logic             sync_trig_o,
  input logic [CNT_W-1:0] delay_o,
  input logic             restart
);
  logic [CNT_W:0] gap_q;
  logic           seen_q;
  logic           restart_q;
  logic           per_chg_q;
  logic [CNT_W-1:0] per_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gap_q     <= '0;
      seen_q    <= 1'b0;
      restart_q <= 1'b0;
      per_chg_q <= 1'b0;
      per_q     <= '0;
    end else begin
      restart_q <= restart;
      per_q     <= period_i;
      if (tick_o) begin
        gap_q     <= {{CNT_W{1'b0}}, 1'b1};
        seen_q    <= 1'b1;
        per_chg_q <= 1'b0;
      end else begin
        if (gap_q != {(CNT_W+1){1'b1}}) gap_q <= gap_q + 1'b1;
        if (per_q != period_i) per_chg_q <= 1'b1;
      end
    end
  end

  // R2: tick spacing equals the period when nothing disturbed the phase
  assert_tick_spacing_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (tick_o && seen_q && !restart_q && !per_chg_q && (per_q == period_i))
      |-> (gap_q == {1'b0, period_i}));

  // R3: alignment completes on a tick
  assert_aligned_on_tick_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(aligned_o) |-> tick_o);

  // R4: a request drops alignment
  assert_req_drops_aligned_R4: assert property (@(posedge clk) disable iff (!rst_n)
    align_req_i |=> !aligned_o);

  // R5: no output trigger while unaligned
  assert_no_pulse_unaligned_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !aligned_o |-> !sync_trig_o);

  // R6: pulses land on ticks and last one cycle
  assert_pulse_on_tick_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_trig_o |-> tick_o);
  assert_pulse_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
    sync_trig_o |=> !sync_trig_o);

  // R8: delay moves only after a pulse and stays in range
  assert_delay_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(delay_o) |-> $past(sync_trig_o));
  assert_delay_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sync_trig_o) |-> ((delay_o >= 1) && (delay_o <= period_i)));
endmodule

bind xdev_trig_sync xdev_trig_sync_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .period_i    (period_i),
  .align_req_i (align_req_i),
  .tick_o      (tick_o),
  .aligned_o   (aligned_o),
  .sync_trig_o (sync_trig_o),
  .delay_o     (delay_o),
  .restart     (restart)
);

// File: tb/xdev_trig_sync_tb.sv
`timescale 1ns/1ps
module xdev_trig_sync_tb;
  localparam int CW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CW-1:0] period_i = 16'd8;
  logic          align_req_i = 1'b0;
  logic          ref_clk_i = 1'b0;
  logic          trig_i = 1'b0;
  logic          tick_o, aligned_o, sync_trig_o;
  logic [CW-1:0] delay_o;

  always #2.5 clk = ~clk;

  xdev_trig_sync #(.CNT_W(CW), .SYNC_STAGES(2)) u_dut (
    .clk(clk), .rst_n(rst_n), .period_i(period_i), .align_req_i(align_req_i),
    .ref_clk_i(ref_clk_i), .trig_i(trig_i), .tick_o(tick_o), .aligned_o(aligned_o),
    .sync_trig_o(sync_trig_o), .delay_o(delay_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // behavioural model state
  int m_phase, m_armed, m_aligned, m_refprev, m_pend, m_dcnt, m_delay;
  int trig_hist[$];
  int ref_ctr = 0;
  int pulses = 0;
  int seen_min = 1000, seen_max = 0;

  task automatic check(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic model_reset();
    m_phase = 0; m_armed = 0; m_aligned = 0; m_refprev = 0;
    m_pend = 0; m_dcnt = 0; m_delay = 0;
    trig_hist.delete();
    repeat (4) trig_hist.push_front(0);
  endtask

  // One cycle: compare, drive ref, predict, clock.
  task automatic step();
    int exp_tick, rref, det, fire, take, per;
    int n_phase, n_armed, n_aligned, n_pend, n_dcnt, n_delay;
    exp_tick = (m_phase == 0);
    check("R2", "tick_o", int'(tick_o), exp_tick);
    check("R4", "aligned_o", int'(aligned_o), m_aligned);
    check("R6", "sync_trig_o", int'(sync_trig_o), (exp_tick && m_pend) ? 1 : 0);
    check("R8", "delay_o", int'(delay_o), m_delay);
    if (sync_trig_o) pulses++;
    ref_clk_i = (ref_ctr % 4) >= 2;
    ref_ctr++;
    per = int'(period_i);
    trig_hist.push_front(int'(trig_i));
    if (trig_hist.size() > 6) void'(trig_hist.pop_back());
    rref = (ref_clk_i && !m_refprev) ? 1 : 0;
    det  = (trig_hist[2] == 1 && trig_hist[3] == 0) ? 1 : 0;
    fire = (exp_tick && m_pend) ? 1 : 0;
    take = (det && m_aligned && !m_pend && !align_req_i) ? 1 : 0;
    n_phase   = (m_armed && rref) ? 0 : ((m_phase >= per - 1) ? 0 : m_phase + 1);
    n_aligned = align_req_i ? 0 : ((m_armed && rref) ? 1 : m_aligned);
    n_armed   = align_req_i ? 1 : (rref ? 0 : m_armed);
    n_pend    = (align_req_i || fire) ? 0 : (take ? 1 : m_pend);
    n_dcnt    = take ? 1 : ((m_pend && !fire && m_dcnt < per) ? m_dcnt + 1 : m_dcnt);
    n_delay   = fire ? m_dcnt : m_delay;
    @(posedge clk);
    m_phase = n_phase; m_aligned = n_aligned; m_armed = n_armed; m_pend = n_pend;
    m_dcnt = n_dcnt; m_delay = n_delay; m_refprev = int'(ref_clk_i);
    @(negedge clk);
  endtask

  task automatic wait_phase0();
    while (m_phase != 0) step();
  endtask

  task automatic do_align();
    int waited = 0;
    align_req_i = 1'b1; step(); align_req_i = 1'b0;
    while (!aligned_o && waited < 12) begin step(); waited++; end
    // R3: reference edge within one ref period plus register latency
    check("R3", "aligned after request", int'(aligned_o), 1);
    check("R3", "tick on alignment cycle", int'(tick_o), 1);
  endtask

  task automatic sweep_offsets();
    int n = int'(period_i);
    for (int k = 0; k < n; k++) begin
      wait_phase0();
      for (int j = 0; j < k; j++) step();
      trig_i = 1'b1; step(); trig_i = 1'b0;
      for (int j = 0; j < 2 * n + 2; j++) step();
      if (int'(delay_o) < seen_min) seen_min = int'(delay_o);
      if (int'(delay_o) > seen_max) seen_max = int'(delay_o);
    end
    check("R8", "smallest delay over offsets", seen_min, 1);
    check("R8", "largest delay over offsets", seen_max, n);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog run did not finish actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int p0;
    model_reset();
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", "aligned_o in reset", int'(aligned_o), 0);
    check("R1", "sync_trig_o in reset", int'(sync_trig_o), 0);
    check("R1", "delay_o in reset", int'(delay_o), 0);
    check("R1", "tick_o in reset", int'(tick_o), 1);
    rst_n = 1'b1;
    check("R1", "tick_o first cycle", int'(tick_o), 1);

    // R5: trigger before alignment is dropped
    repeat (5) step();
    trig_i = 1'b1; repeat (3) step(); trig_i = 1'b0;
    p0 = pulses;
    repeat (20) step();
    check("R5", "pulses while unaligned", pulses - p0, 0);
    check("R5", "delay_o untouched", int'(delay_o), 0);

    do_align();
    // R6, R8 across all offsets with N=8
    sweep_offsets();

    // R7: second edge within pending window
    wait_phase0();
    p0 = pulses;
    trig_i = 1'b1; step(); trig_i = 1'b0; step();
    trig_i = 1'b1; step(); trig_i = 1'b0;
    repeat (20) step();
    check("R7", "pulses for two close edges", pulses - p0, 1);

    // R4: realign while pending discards the trigger
    wait_phase0();
    step();
    trig_i = 1'b1; step(); trig_i = 1'b0;
    repeat (3) step();
    p0 = pulses;
    align_req_i = 1'b1; step(); align_req_i = 1'b0;
    check("R4", "aligned_o after request", int'(aligned_o), 0);
    repeat (24) step();
    check("R4", "pulses after flush", pulses - p0, 0);
    check("R4", "realigned", int'(aligned_o), 1);

    // different period, realigned
    period_i = 16'd5;
    seen_min = 1000; seen_max = 0;
    repeat (3) step();
    do_align();
    sweep_offsets();

    repeat (10) step();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule